// File: doc/BRIEF.md
# Synchronous Transmit Fault Supervisor

This block watches a byte-oriented synchronous transmitter while it sends a frame. It looks for two faults. The first is a data underrun: the serializer asks for a byte and the supplier has none ready. The second is loss of clear-to-send. When either fault occurs, the block takes away permission to send and pulses a buffer-close strobe. It latches a status flag that names the fault, and it can raise a one-clock transmit-error interrupt.

After a fault the transmitter stays halted until a restart command arrives. Restart gives back permission to send but leaves the latched status flags as they are. Software clears the flags with a separate acknowledge input.

Two situations never count as an underrun: a byte request outside a frame, and a byte request inside a transparent-mode escape pair. An escape pair is the escape character together with the character that follows it.

Top module: `bsy_txerr_ctrl`

## Requirements
- R1: After reset, send_en is 1, and buf_close, stat_underrun, stat_ctslost and irq are all 0.
- R2: An underrun is byte_req=1 with byte_valid=0 while frame_active=1, esc_pair=0, cts=1 and send_en=1. On the next cycle it gives send_en=0, buf_close=1 and stat_underrun=1.
- R3: With frame_active=0, neither a byte request without valid data nor cts=0 causes any fault. buf_close and the status flags stay unchanged and send_en stays 1.
- R4: With esc_pair=1, a byte request without valid data is not an underrun.
- R5: cts=0 while frame_active=1 and send_en=1 gives send_en=0, buf_close=1 and stat_ctslost=1 on the next cycle.
- R6: If both faults occur in the same cycle, only stat_ctslost is set. stat_underrun is left unchanged.
- R7: With irq_en=1, the cycle in which buf_close pulses for a fault also carries a one-cycle pulse on irq. With irq_en=0, irq stays 0.
- R8: While send_en=0, no new fault is recorded and buf_close stays 0. restart=1 sets send_en back to 1 on the next cycle and leaves both status flags unchanged.
- R9: ack=1 clears both status flags on the next cycle. A fault detected in the same cycle still sets its flag.
- R10: buf_close is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_active | input | 1 | A frame is being transmitted |
| byte_req | input | 1 | Serializer requests the next byte |
| byte_valid | input | 1 | Supplier has a byte ready |
| esc_pair | input | 1 | Transmitter is inside a transparent escape pair |
| cts | input | 1 | Clear-to-send, 1 means clear |
| restart | input | 1 | Restart-transmit command |
| ack | input | 1 | Clears the latched status flags |
| irq_en | input | 1 | Interrupt mask bit, 1 enables irq |
| send_en | output | 1 | Permission to transmit, 0 while halted |
| buf_close | output | 1 | One-cycle pulse that closes the current buffer |
| stat_underrun | output | 1 | Latched underrun status |
| stat_ctslost | output | 1 | Latched clear-to-send-lost status |
| irq | output | 1 | Transmit-error interrupt pulse |

## Verification
The assertions assume that rst_n is held low for at least one clock edge before any property is evaluated. They also assume that every input is a synchronous level that stays steady across the sampling edge.

The bench changes inputs only on the falling edge and samples the registered outputs one nanosecond after the rising edge. This keeps the stimulus within those assumptions. It also holds cts high whenever a case is meant to isolate the underrun path.

// File: rtl/bsy_txerr_ctrl.sv
module bsy_txerr_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_active,
  input  logic byte_req,
  input  logic byte_valid,
  input  logic esc_pair,
  input  logic cts,
  input  logic restart,
  input  logic ack,
  input  logic irq_en,
  output logic send_en,
  output logic buf_close,
  output logic stat_underrun,
  output logic stat_ctslost,
  output logic irq
);

  logic halted;
  logic flt_un, flt_cts, flt_any;

  assign flt_cts = !halted && frame_active && !cts;
  assign flt_un  = !halted && frame_active && byte_req && !byte_valid && !esc_pair;
  assign flt_any = flt_cts || flt_un;
  assign send_en = !halted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted        <= 1'b0;
      buf_close     <= 1'b0;
      stat_underrun <= 1'b0;
      stat_ctslost  <= 1'b0;
      irq           <= 1'b0;
    end else begin
      if (flt_any)
        halted <= 1'b1;
      else if (restart)
        halted <= 1'b0;
      buf_close     <= flt_any;
      irq           <= flt_any && irq_en;
      stat_ctslost  <= flt_cts || (stat_ctslost && !ack);
      stat_underrun <= (flt_un && !flt_cts) || (stat_underrun && !ack);
    end
  end

endmodule

// File: rtl/bsy_txerr_ctrl_chk.sv
module bsy_txerr_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_active,
  input logic byte_req,
  input logic byte_valid,
  input logic esc_pair,
  input logic cts,
  input logic restart,
  input logic ack,
  input logic irq_en,
  input logic send_en,
  input logic buf_close,
  input logic stat_underrun,
  input logic stat_ctslost,
  input logic irq
);

  a_r2_underrun_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (send_en && frame_active && byte_req && !byte_valid && !esc_pair && cts)
      |=> (stat_underrun && buf_close && !send_en));

  a_r3_idle_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (send_en && !frame_active) |=> !buf_close);

  a_r4_escape_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    (send_en && esc_pair && cts) |=> !buf_close);

  a_r5_cts_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (send_en && frame_active && !cts) |=> (stat_ctslost && buf_close && !send_en));

  a_r6_cts_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (send_en && frame_active && !cts && byte_req && !byte_valid && !esc_pair && !stat_underrun)
      |=> !stat_underrun);

  a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (buf_close && $past(irq_en)));

  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r8_stays_halted: assert property (@(posedge clk) disable iff (!rst_n)
    (!send_en && !restart) |=> !send_en);

  a_r8_no_new_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !send_en |=> !buf_close);

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> ((!stat_underrun && !stat_ctslost) || buf_close));

  a_r10_close_single: assert property (@(posedge clk) disable iff (!rst_n)
    buf_close |=> !buf_close);

endmodule

bind bsy_txerr_ctrl bsy_txerr_ctrl_chk chk_i (.*);

// File: tb/bsy_txerr_ctrl_tb.sv
`timescale 1ns/1ps
module bsy_txerr_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_active, byte_req, byte_valid, esc_pair, cts, restart, ack, irq_en;
  logic send_en, buf_close, stat_underrun, stat_ctslost, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bsy_txerr_ctrl dut_i (.*);

  // vector: {frame,req,valid,esc,cts,restart,ack,ien, send,close,un,ct,irq}
  localparam int NV = 16;
  localparam logic [12:0] VEC [NV] = '{
    13'b00001001_10000,
    13'b11101001_10000,
    13'b01001001_10000,
    13'b11011001_10000,
    13'b11001001_01101,
    13'b11000001_00100,
    13'b00001101_10100,
    13'b00001011_10000,
    13'b00000001_10000,
    13'b10000000_01010,
    13'b00001110_10000,
    13'b11000001_01011,
    13'b00001101_10010,
    13'b11001011_01101,
    13'b00001001_00100,
    13'b00001101_10100
  };

  task automatic drive(input logic [7:0] v);
    @(negedge clk);
    {frame_active, byte_req, byte_valid, esc_pair, cts, restart, ack, irq_en} = v;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    {frame_active, byte_req, byte_valid, esc_pair, cts, restart, ack, irq_en} = 8'b00001001;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 send_en", send_en, 1'b1);
    chk("R1 buf_close", buf_close, 1'b0);
    chk("R1 stat_underrun", stat_underrun, 1'b0);
    chk("R1 stat_ctslost", stat_ctslost, 1'b0);
    chk("R1 irq", irq, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][12:5]);
      chk("R8 send_en", send_en, VEC[i][4]);
      chk("R10 buf_close", buf_close, VEC[i][3]);
      chk("R2 stat_underrun", stat_underrun, VEC[i][2]);
      chk("R5 stat_ctslost", stat_ctslost, VEC[i][1]);
      chk("R7 irq", irq, VEC[i][0]);
    end

    // clear stale underrun flag
    drive(8'b00001011);
    chk("R9 ack clears", stat_underrun, 1'b0);

    // R3: long run outside a frame, requests without data and cts low
    for (int k = 0; k < 5; k++) begin
      drive(8'b01000001);
      chk("R3 no fault outside frame", buf_close, 1'b0);
      chk("R3 still enabled", send_en, 1'b1);
    end

    // R4: escape pair held for several requests
    for (int k = 0; k < 3; k++) begin
      drive(8'b11011001);
      chk("R4 escape ignored", stat_underrun, 1'b0);
      chk("R4 still enabled", send_en, 1'b1);
    end

    // R6: both faults at once with the underrun flag clear
    drive(8'b11000001);
    chk("R6 ct set", stat_ctslost, 1'b1);
    chk("R6 un not set", stat_underrun, 1'b0);
    chk("R7 irq with both faults", irq, 1'b1);

    // R8: restart leaves the flag set
    drive(8'b00001101);
    chk("R8 restart resumes", send_en, 1'b1);
    chk("R8 flag kept", stat_ctslost, 1'b1);

    // R1: reset in the middle of a run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 mid reset ct", stat_ctslost, 1'b0);
    chk("R1 mid reset send", send_en, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule